// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital side of a 10-bit successive-approximation converter. Software drives it through one 8-bit control register. The register holds a power-up bit, a launch bit, a continuous-mode bit, an interrupt enable, a sticky completion flag and a 3-bit clock-divider code. The divider turns the system clock into a converter tick. On each tick the sequencer steps one phase of a conversion. It puts a trial code on `dac_code` and reads back a single comparator bit, `cmp_in`, that tells it whether the sampled input is at or above that trial level.

A normal conversion takes 13 ticks. The first conversion after power-up takes 25 ticks, because it also warms up the analog side. At the end of a conversion the sequencer pulses `res_valid` for one cycle, updates `res_code` and raises the completion flag. The interrupt request is the completion flag gated by the local interrupt enable and the global enable `gie`. In continuous mode the sequencer starts a new conversion by itself each time one completes.

A separate 7-bit channel/reference selection is held as a pending value. It is copied to `sel_active` only while the converter is powered. This models when a new selection takes effect.

Top module: `sar_seq_ctrl`

## Requirements
- R1: Control register layout, the same for writes and reads: bit 0 power, bit 1 launch (reads 1 while converting), bit 2 continuous, bit 3 interrupt enable, bit 4 completion flag, bits 7:5 divider code. After reset the read value is 0x00, `dac_code` is 0, and `res_valid` and `irq` are 0.
- R2: Divider codes 0 to 7 give 2, 2, 4, 8, 16, 32, 64 and 128 system clocks per converter tick. The divider restarts at the clock edge that launches a conversion.
- R3: A normal conversion puts its `res_valid` pulse in the cycle after the 13×D-th rising edge following the launching edge, where D is the divide ratio.
- R4: The first conversion after power-up lasts 25 ticks. This also holds when power and launch are written in the same write.
- R5: A write of launch = 0 has no effect. So has a launch written while the power bit of the same write is 0, and a launch written while a conversion is running. Bit 1 reads 1 from the launching edge until the conversion completes.
- R6: The result is built MSB first. Each trial bit is kept when `cmp_in` is 1 (input at or above the trial code on `dac_code`). With an ideal comparator the result equals the input code: 0 is ground, 1023 is full scale minus one LSB.
- R7: In continuous mode a new 13-tick conversion starts at every completion, so pulses come 13×D cycles apart and each carries a fresh result. Clearing bit 2 lets the running conversion finish and then stops.
- R8: Writing power = 0 abandons a running conversion: no `res_valid` pulse follows and bit 1 reads 0. The next conversion after power returns is again a 25-tick one.
- R9: The completion flag sets together with the `res_valid` pulse. It clears on a control write with bit 4 = 1 or on an `irq_ack` pulse, and a write with bit 4 = 0 leaves it unchanged. A completion in the same cycle as a clear wins.
- R10: `irq` is 1 exactly when the completion flag, the interrupt enable and `gie` are all 1.
- R11: `sel_active` takes the value written on `sel_wdata` by the second rising edge after the write, but only while the power bit is 1. While the power bit is 0 it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read value |
| sel_wr | input | 1 | Channel/reference selection write strobe |
| sel_wdata | input | 7 | Channel/reference selection write data |
| sel_active | output | 7 | Selection currently in effect |
| cmp_in | input | 1 | Comparator: 1 when input is at or above `dac_code` |
| dac_code | output | 10 | Trial code presented to the comparator |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge, clears the completion flag |
| irq | output | 1 | Interrupt request |
| res_valid | output | 1 | One-cycle result strobe |
| res_code | output | 10 | Last conversion result |

## Verification
Each result is due a fixed number of edges after the launching edge: L×D, with L of 13 or 25 and D the divide ratio. In continuous mode the next result is due 13×D edges after the previous pulse. The bench counts rising edges from the launching write and samples `res_valid` on falling edges, so a pulse that comes early or late shows up as a wrong edge count. Flag, interrupt and launch-bit effects appear on the edge of the write or acknowledge. The selection appears one edge later, and the bench samples each of them on the falling edge just after it.

// File: rtl/sar_seq_pkg.sv
// Package: shared widths, tick counts and control-register field positions
// for the successive-approximation sequencer. Assumes an 8-bit control word.
package sar_seq_pkg;
    localparam int RES_W       = 10;  // result width
    localparam int SHORT_TICKS = 13;  // ticks per normal conversion
    localparam int LONG_TICKS  = 25;  // ticks for the first conversion after power-up
    localparam int PSC_W       = 3;   // divider code width
    localparam int SEL_W       = 7;   // channel/reference selection width

    // Control register field positions (read and write share them)
    localparam int F_EN   = 0;
    localparam int F_GO   = 1;
    localparam int F_FR   = 2;
    localparam int F_IE   = 3;
    localparam int F_DONE = 4;
    localparam int F_PSC  = 5;
endpackage

// File: rtl/sar_clk_div.sv
// Converter tick generator. It divides the system clock by 2 for code 0 and
// by 2**code otherwise. It is held at zero while not running and restarts
// when asked. Assumes the code may change at any time; a counter already past
// the new limit wraps at once.
module sar_clk_div #(
    parameter int PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);
    localparam int CNT_W = (1 << PSC_W) - 1;

    logic [CNT_W:0]   div_w;
    logic [CNT_W-1:0] cnt;
    logic             wrap;

    // Divide ratio for the current code
    always_comb begin
        if (psc == '0) div_w = (CNT_W+1)'(2);
        else           div_w = (CNT_W+1)'(1) << psc;
    end

    assign wrap = (({1'b0, cnt} + (CNT_W+1)'(1)) >= div_w);
    assign tick = run && wrap;

    // Phase counter: cleared on restart or power-down, wraps at the ratio
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (clr || !run)   cnt <= '0;
        else if (wrap)          cnt <= '0;
        else                    cnt <= cnt + CNT_W'(1);
    end

    // R2: after a tick the divider restarts its phase
    assert_div_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick) |=> (cnt == '0));
endmodule

// File: rtl/sar_bit_engine.sv
// Successive-approximation engine. On a launch it loads the MSB trial and
// counts converter ticks. The trial window is the RES_W ticks just before the
// last tick. In that window one bit is decided per tick, MSB first, and the
// next lower bit is set as the new trial. Completion is flagged on the final
// tick. Assumes launch and abort never come together with abort meaning go.
module sar_bit_engine #(
    parameter int RES_W       = 10,
    parameter int SHORT_TICKS = 13,
    parameter int LONG_TICKS  = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             go,
    input  logic             first,
    input  logic             abort,
    input  logic             cmp_in,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] trial,
    output logic [RES_W-1:0] result
);
    localparam int TCNT_W = $clog2(LONG_TICKS + 1);

    logic [TCNT_W-1:0] tcnt;
    logic [TCNT_W-1:0] len_q;
    logic [TCNT_W-1:0] k_now;
    logic [TCNT_W-1:0] bit_idx;
    logic              in_trial;
    logic [RES_W-1:0]  hit;
    logic [RES_W-1:0]  sar;

    assign k_now    = tcnt + TCNT_W'(1);
    assign bit_idx  = len_q - TCNT_W'(1) - k_now;
    assign in_trial = (k_now < len_q) &&
                      (({1'b0, k_now} + (TCNT_W+1)'(RES_W)) >= {1'b0, len_q});
    assign done     = busy && tick && !abort && (k_now == len_q);

    // Sequencing state: launch, per-tick count, completion, abort
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            tcnt  <= '0;
            len_q <= TCNT_W'(SHORT_TICKS);
        end else if (abort) begin
            busy <= 1'b0;
            tcnt <= '0;
        end else if (go) begin
            busy  <= 1'b1;
            tcnt  <= '0;
            len_q <= first ? TCNT_W'(LONG_TICKS) : TCNT_W'(SHORT_TICKS);
        end else if (busy && tick) begin
            tcnt <= k_now;
            if (k_now == len_q) busy <= 1'b0;
        end
    end

    // One register per result bit: decided on its own trial tick, set as trial on the tick above
    for (genvar i = 0; i < RES_W; i++) begin : g_bit
        logic b_q;
        assign hit[i] = busy && tick && !abort && in_trial && (bit_idx == TCNT_W'(i));
        if (i == RES_W - 1) begin : g_top
            // MSB: loaded as the first trial on launch
            always_ff @(posedge clk) begin
                if (!rst_n)      b_q <= 1'b0;
                else if (abort)  b_q <= 1'b0;
                else if (go)     b_q <= 1'b1;
                else if (hit[i]) b_q <= cmp_in;
            end
        end else begin : g_low
            // Lower bits: become the trial once the bit above is decided
            always_ff @(posedge clk) begin
                if (!rst_n)        b_q <= 1'b0;
                else if (abort)    b_q <= 1'b0;
                else if (go)       b_q <= 1'b0;
                else if (hit[i])   b_q <= cmp_in;
                else if (hit[i+1]) b_q <= 1'b1;
            end
        end
        assign sar[i] = b_q;
    end

    assign trial  = sar;
    assign result = sar;

    // R8: an abort leaves the engine idle
    assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !busy);
    // R4: only the two legal conversion lengths ever run
    assert_len_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (len_q == TCNT_W'(SHORT_TICKS) || len_q == TCNT_W'(LONG_TICKS)));
    // R6: the trial code moves only on a tick, launch or abort
    assert_trial_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick && !go && !abort) |=> $stable(sar));
    // R6: at most one bit decided per tick
    assert_one_decision_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
endmodule

// File: rtl/sar_ctl_regs.sv
// Control register file. It holds power, continuous, interrupt-enable,
// divider code and the sticky completion flag. It decides when a conversion
// launches (software or continuous retrigger) and whether it is a first one.
// It also produces the interrupt request and tracks the selection in effect.
// Assumes `busy` and `done` come from the engine in the same cycle.
module sar_ctl_regs
    import sar_seq_pkg::*;
#(
    parameter int PW = 3,
    parameter int SW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic [PW+4:0] ctl_wdata,
    output logic [PW+4:0] ctl_rdata,
    input  logic          sel_wr,
    input  logic [SW-1:0] sel_wdata,
    output logic [SW-1:0] sel_active,
    input  logic          gie,
    input  logic          irq_ack,
    output logic          irq,
    input  logic          busy,
    input  logic          done,
    output logic          en_q,
    output logic          en_next,
    output logic [PW-1:0] psc_q,
    output logic          go,
    output logic          first
);
    logic          fr_q, ie_q, flag_q, init_q;
    logic          start_req;
    logic [SW-1:0] sel_pend, sel_act;

    assign en_next   = ctl_wr ? ctl_wdata[F_EN] : en_q;
    assign start_req = ctl_wr && ctl_wdata[F_GO] && ctl_wdata[F_EN] && !busy;
    assign go        = start_req || (done && fr_q);
    assign first     = !init_q;

    // Plain configuration fields, loaded on every control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            fr_q  <= 1'b0;
            ie_q  <= 1'b0;
            psc_q <= '0;
        end else if (ctl_wr) begin
            en_q  <= ctl_wdata[F_EN];
            fr_q  <= ctl_wdata[F_FR];
            ie_q  <= ctl_wdata[F_IE];
            psc_q <= ctl_wdata[F_PSC +: PW];
        end
    end

    // Warm-up tracking: first launch after power-up is a long one
    always_ff @(posedge clk) begin
        if (!rst_n)        init_q <= 1'b0;
        else if (!en_next) init_q <= 1'b0;
        else if (go)       init_q <= 1'b1;
    end

    // Completion flag: set wins over write-one-to-clear and acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)                                     flag_q <= 1'b0;
        else if (done)                                  flag_q <= 1'b1;
        else if ((ctl_wr && ctl_wdata[F_DONE]) || irq_ack) flag_q <= 1'b0;
    end

    // Selection: pending copy always written, active copy only follows while powered
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_pend <= '0;
            sel_act  <= '0;
        end else begin
            if (sel_wr) sel_pend <= sel_wdata;
            if (en_q)   sel_act  <= sel_pend;
        end
    end

    assign sel_active = sel_act;
    assign irq        = flag_q && ie_q && gie;
    assign ctl_rdata  = {psc_q, flag_q, ie_q, fr_q, busy, en_q};

    // R9: a completion always leaves the flag set
    assert_flag_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> flag_q);
    // R9: acknowledge without a competing completion clears the flag
    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !done) |=> !flag_q);
    // R5: no launch while the converter is being powered down
    assert_go_needs_power_R5: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> en_next);
    // R11: selection frozen while unpowered
    assert_sel_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> $stable(sel_act));
endmodule

// File: rtl/sar_seq_ctrl.sv
// Top of the successive-approximation sequencer. It joins the control
// registers, the tick divider and the bit engine, and registers the result
// and its one-cycle strobe. Assumes a comparator that settles within one
// system clock of a `dac_code` change.
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int RES_BITS   = RES_W,
    parameter int NORM_TICKS = SHORT_TICKS,
    parameter int INIT_TICKS = LONG_TICKS,
    parameter int DIV_BITS   = PSC_W,
    parameter int SEL_BITS   = SEL_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctl_wr,
    input  logic [DIV_BITS+4:0]   ctl_wdata,
    output logic [DIV_BITS+4:0]   ctl_rdata,
    input  logic                  sel_wr,
    input  logic [SEL_BITS-1:0]   sel_wdata,
    output logic [SEL_BITS-1:0]   sel_active,
    input  logic                  cmp_in,
    output logic [RES_BITS-1:0]   dac_code,
    input  logic                  gie,
    input  logic                  irq_ack,
    output logic                  irq,
    output logic                  res_valid,
    output logic [RES_BITS-1:0]   res_code
);
    logic                en_q, en_next, go, first, tick, busy, done;
    logic [DIV_BITS-1:0] psc_q;
    logic [RES_BITS-1:0] result;

    sar_ctl_regs #(.PW(DIV_BITS), .SW(SEL_BITS)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .sel_wr(sel_wr), .sel_wdata(sel_wdata), .sel_active(sel_active),
        .gie(gie), .irq_ack(irq_ack), .irq(irq),
        .busy(busy), .done(done),
        .en_q(en_q), .en_next(en_next), .psc_q(psc_q),
        .go(go), .first(first)
    );

    sar_clk_div #(.PSC_W(DIV_BITS)) u_div (
        .clk(clk), .rst_n(rst_n),
        .run(en_q), .clr(go || !en_next), .psc(psc_q),
        .tick(tick)
    );

    sar_bit_engine #(
        .RES_W(RES_BITS), .SHORT_TICKS(NORM_TICKS), .LONG_TICKS(INIT_TICKS)
    ) u_eng (
        .clk(clk), .rst_n(rst_n),
        .tick(tick), .go(go), .first(first), .abort(!en_next),
        .cmp_in(cmp_in),
        .busy(busy), .done(done), .trial(dac_code), .result(result)
    );

    // Result capture and completion strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_code  <= '0;
        end else begin
            res_valid <= done;
            if (done) res_code <= result;
        end
    end

    // R3: strobe is a single cycle (conversions last far longer)
    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    // R8: no result strobe follows a power-down
    assert_no_result_unpowered_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_next |=> !res_valid);
endmodule

// File: tb/sim_sar_seq_ctrl.sv
module sim_sar_seq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic [7:0] ctl_rdata;
    logic       sel_wr = 1'b0;
    logic [6:0] sel_wdata = '0;
    logic [6:0] sel_active;
    logic       cmp_in;
    logic [9:0] dac_code;
    logic       gie = 1'b0;
    logic       irq_ack = 1'b0;
    logic       irq;
    logic       res_valid;
    logic [9:0] res_code;
    logic [9:0] vin = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Ideal comparator model
    assign cmp_in = (vin >= dac_code);

    sar_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .sel_wr(sel_wr), .sel_wdata(sel_wdata), .sel_active(sel_active),
        .cmp_in(cmp_in), .dac_code(dac_code),
        .gie(gie), .irq_ack(irq_ack), .irq(irq),
        .res_valid(res_valid), .res_code(res_code)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int div_of(input int code);
        return (code == 0) ? 2 : (1 << code);
    endfunction

    // Drive one control write; returns just after the consuming edge
    task automatic wr_ctl(input logic [7:0] d);
        @(negedge clk);
        ctl_wr = 1'b1;
        ctl_wdata = d;
        @(posedge clk);
        #1;
        ctl_wr = 1'b0;
    endtask

    // Count rising edges until res_valid is seen on a falling edge
    task automatic wait_valid(input int lim, output int n);
        n = 0;
        forever begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (res_valid || n > lim) break;
        end
    endtask

    task automatic count_valid(input int cycles, output int cnt);
        cnt = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (res_valid) cnt++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        int c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ctl_rdata == 8'h00, "R1 reset rdata", ctl_rdata, 0);
        chk(dac_code == 0, "R1 reset dac_code", dac_code, 0);
        chk(!res_valid && !irq, "R1 reset strobes", {res_valid, irq}, 0);

        // R5 launch ignored while unpowered
        wr_ctl(8'h02);
        count_valid(100, c);
        chk(c == 0, "R5 launch unpowered", c, 0);
        chk(ctl_rdata == 8'h00, "R5 rdata unpowered", ctl_rdata, 0);

        // R4 power+launch together: long conversion
        vin = 10'd513;
        wr_ctl(8'h03);
        chk(ctl_rdata[1] == 1'b1, "R5 busy reads 1", ctl_rdata[1], 1);
        wait_valid(5000, n);
        chk(n == 25 * 2, "R4 first conversion edges", n, 50);
        chk(res_code == 10'd513, "R6 first result", res_code, 513);
        chk(ctl_rdata[4] == 1'b1, "R9 flag set", ctl_rdata[4], 1);
        chk(ctl_rdata[1] == 1'b0, "R5 busy cleared", ctl_rdata[1], 0);

        // R9 write-one-to-clear
        wr_ctl(8'h11);
        chk(ctl_rdata == 8'h01, "R9 w1c flag", ctl_rdata, 1);

        // R6 and R3: exhaustive input sweep at divider code 0
        for (int v = 0; v < 1024; v++) begin
            vin = 10'(v);
            wr_ctl(8'h03);
            wait_valid(5000, n);
            chk(n == 13 * 2, "R3 normal conversion edges", n, 26);
            chk(res_code == 10'(v), "R6 sweep result", res_code, v);
        end

        // R2 every divider code
        for (int k = 1; k < 8; k++) begin
            vin = 10'(k * 97);
            wr_ctl(8'(k << 5) | 8'h03);
            wait_valid(5000, n);
            chk(n == 13 * div_of(k), "R2 divider ratio", n, 13 * div_of(k));
            chk(res_code == 10'(k * 97), "R6 divided result", res_code, k * 97);
        end

        // R7 continuous mode
        vin = 10'd100;
        wr_ctl(8'h07);
        wait_valid(5000, n);
        chk(n == 26, "R7 first continuous", n, 26);
        chk(res_code == 10'd100, "R7 first result", res_code, 100);
        for (int j = 0; j < 3; j++) begin
            vin = 10'(200 + j * 111);
            wait_valid(5000, n);
            chk(n == 26, "R7 retrigger spacing", n, 26);
            chk(res_code == 10'(200 + j * 111), "R7 refreshed result", res_code, 200 + j * 111);
        end
        wr_ctl(8'h01);
        wait_valid(5000, n);
        chk(n == 24, "R7 running conversion finishes", n, 24);
        count_valid(200, c);
        chk(c == 0, "R7 stops after clear", c, 0);
        chk(ctl_rdata[1] == 1'b0, "R7 idle after stop", ctl_rdata[1], 0);

        // R8 abort by power-down, then a long conversion again
        wr_ctl(8'h03);
        repeat (10) @(posedge clk);
        wr_ctl(8'h00);
        count_valid(100, c);
        chk(c == 0, "R8 no result after abort", c, 0);
        chk(ctl_rdata[1] == 1'b0, "R8 busy cleared", ctl_rdata[1], 0);
        vin = 10'd777;
        wr_ctl(8'h43);
        wait_valid(5000, n);
        chk(n == 25 * 4, "R8 long after re-power", n, 100);
        chk(res_code == 10'd777, "R8 result after re-power", res_code, 777);

        // R5 launch while busy and launch=0 while busy: no effect
        vin = 10'd5;
        wr_ctl(8'h03);
        wr_ctl(8'h03);
        wait_valid(5000, n);
        chk(n == 25, "R5 relaunch while busy", n, 25);
        chk(res_code == 10'd5, "R5 result unchanged", res_code, 5);
        vin = 10'd1023;
        wr_ctl(8'h03);
        wr_ctl(8'h01);
        chk(ctl_rdata[1] == 1'b1, "R5 launch 0 keeps busy", ctl_rdata[1], 1);
        wait_valid(5000, n);
        chk(n == 25, "R5 launch 0 no effect", n, 25);
        chk(res_code == 10'd1023, "R6 full scale", res_code, 1023);

        // R10 interrupt gating and R9 acknowledge
        wr_ctl(8'h09);
        @(negedge clk);
        chk(irq == 1'b0, "R10 gie low", irq, 0);
        gie = 1'b1;
        @(negedge clk);
        chk(irq == 1'b1, "R10 all enables", irq, 1);
        irq_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        irq_ack = 1'b0;
        chk(ctl_rdata[4] == 1'b0, "R9 ack clears", ctl_rdata[4], 0);
        chk(irq == 1'b0, "R10 irq after ack", irq, 0);
        vin = 10'd300;
        wr_ctl(8'h0B);
        wait_valid(5000, n);
        chk(irq == 1'b1, "R10 irq on completion", irq, 1);
        wr_ctl(8'h01);
        chk(irq == 1'b0, "R10 ie cleared", irq, 0);
        chk(ctl_rdata[4] == 1'b1, "R9 write 0 keeps flag", ctl_rdata[4], 1);

        // R11 selection only follows while powered
        wr_ctl(8'h00);
        @(negedge clk);
        sel_wr = 1'b1;
        sel_wdata = 7'h55;
        @(posedge clk);
        #1;
        sel_wr = 1'b0;
        repeat (5) @(negedge clk);
        chk(sel_active == 7'h00, "R11 held unpowered", sel_active, 0);
        wr_ctl(8'h01);
        @(posedge clk);
        @(negedge clk);
        chk(sel_active == 7'h55, "R11 applied on power", sel_active, 'h55);
        @(negedge clk);
        sel_wr = 1'b1;
        sel_wdata = 7'h2A;
        @(posedge clk);
        #1;
        sel_wr = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(sel_active == 7'h2A, "R11 powered update", sel_active, 'h2A);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule